// File: doc/BRIEF.md
# Decimating Averager with Sample Formatting

This block lowers the sample rate of one data channel by a programmable divider. Every incoming 32-bit word is first formatted: either as one 32-bit sample or as two 16-bit samples packed side by side, each interpreted as signed or unsigned and extended from a programmable bit position. The formatted stream is then decimated. With averaging off, one word out of each group is passed on. With averaging on, the block emits the arithmetic mean of the group.

In 16-bit mode the two halves of a word are two independent lanes, and the divider is counted in pairs of samples. Averaging uses an accumulator followed by a right shift. The shift is arithmetic in signed mode and logical in unsigned mode, so only power-of-two group lengths are honoured. The configuration inputs are meant to be held stable while the block runs. Reset restarts the grouping.

Top module: `dec_avg_fmt`

## Requirements
- R1: While reset is low and on the first cycle after it, out_valid is 0 and out_data is 0. Grouping restarts so that the first valid word after reset opens a new group.
- R2: In 32-bit mode (width16=0) with p=sign_pos (0..31), output bits 0..p equal the input bits. Each bit above p equals input bit p when signed_mode=1, and is 0 when signed_mode=0.
- R3: In 16-bit mode (width16=1) bits 15:0 form lane 0 and bits 31:16 form lane 1. Each lane is formatted within its own 16 bits by the rule of R2 with p=sign_pos[3:0], so sign_pos[4] has no effect.
- R4: With avg_en=0 and width16=0, each group holds div valid words. The output is the formatted last word of the group.
- R5: A div of 0 behaves exactly as a div of 1, which passes every valid word.
- R6: With avg_en=0 and width16=1, a group holds floor(div/2) valid words, or 1 word when that is 0. The output is the formatted last word of the group.
- R7: With avg_en=1 and width16=0, let k be the index of the highest set bit of div (div 0 counts as 1), capped at 12. A group holds 2^k valid words. The output is the floor of the mean of their formatted values (signed values in signed mode), taken modulo 2^32.
- R8: With avg_en=1 and width16=1, a group holds 2^(k-1) valid words, or 1 word when k=0, with k as in R7. Each lane outputs the floor of the mean of its own formatted values, modulo 2^16.
- R9: out_valid is 1 exactly on the cycle after the valid word that completes a group. Cycles with in_valid=0 do not advance a group. out_data keeps its value between outputs, and the next group starts with the next valid word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_data | input | 32 | Raw input word (one 32-bit or two 16-bit samples) |
| div | input | 16 | Rate divider |
| avg_en | input | 1 | 1 = output the group mean, 0 = pass the last word of the group |
| width16 | input | 1 | 0 = 32-bit samples, 1 = two 16-bit lanes |
| signed_mode | input | 1 | 0 = unsigned, 1 = signed |
| sign_pos | input | 5 | Bit position from which extension starts |
| out_valid | output | 1 | Decimated output is valid |
| out_data | output | 32 | Decimated, formatted output word |

## Verification
The completion of one group and the opening of the next fall in the same cycle. When a group's last valid word arrives, that word has to be folded into the result being emitted while the accumulator and counter restart, so the following word begins a clean group. The bench provokes this with back-to-back valid words and with idle gaps placed at and around group boundaries, across every width, sign, divider and extension setting in a sweep. Each output word and each hold cycle is compared against a mean and format computed arithmetically with integer division rounded toward minus infinity.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int WORD_W = 32;
  localparam int POS_W  = 5;

  // Keep bits 0..p, fill the bits above p with bit p (signed) or zero.
  function automatic logic [WORD_W-1:0] extend_from(
      input logic [WORD_W-1:0] x,
      input logic [POS_W-1:0]  p,
      input logic              sgn);
    logic [WORD_W-1:0] y;
    for (int i = 0; i < WORD_W; i++) begin
      y[i] = (i <= int'(p)) ? x[i] : (sgn & x[p]);
    end
    return y;
  endfunction
endpackage

// File: rtl/dec_rate.sv
module dec_rate #(
  parameter int DIV_W   = 16,
  parameter int MAX_LOG = 12,
  parameter int LOG_W   = $clog2(DIV_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             avg_en,
  input  logic             width16,
  output logic [DIV_W-1:0] words,
  output logic [LOG_W-1:0] shift
);
  logic [DIV_W-1:0] n0;
  logic [DIV_W-1:0] half_n;
  logic [LOG_W-1:0] msb;
  logic [LOG_W-1:0] kcap;

  always_comb begin
    n0 = (div == '0) ? DIV_W'(1) : div;
    half_n = n0 >> 1;
    msb = '0;
    for (int i = 0; i < DIV_W; i++) begin
      if (n0[i]) msb = LOG_W'(i);
    end
    kcap = (msb > LOG_W'(MAX_LOG)) ? LOG_W'(MAX_LOG) : msb;
    if (avg_en) begin
      if (width16) shift = (kcap == '0) ? '0 : kcap - LOG_W'(1);
      else         shift = kcap;
      words = DIV_W'(1) << shift;
    end else begin
      shift = '0;
      if (width16) words = (half_n == '0) ? DIV_W'(1) : half_n;
      else         words = n0;
    end
  end

  // R7: averaging groups are a single power of two no longer than the cap
  assert_avg_pow2_R7: assert property (@(posedge clk) disable iff (!rst_n)
    avg_en |-> ($countones(words) == 1 && words <= DIV_W'(1 << MAX_LOG)));

  // R5: the decoded group length is never zero
  assert_words_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    words != '0);
endmodule

// File: rtl/dec_format.sv
module dec_format
  import dec_pkg::*;
#(
  parameter int DATA_W = WORD_W,
  parameter int LANES  = 2
) (
  input  logic [DATA_W-1:0] raw,
  input  logic              width16,
  input  logic              signed_mode,
  input  logic [POS_W-1:0]  sign_pos,
  output logic [DATA_W-1:0] fmt
);
  localparam int HALF_W = DATA_W / LANES;

  logic [DATA_W-1:0] full_fmt;
  logic [DATA_W-1:0] lane_fmt;
  logic [POS_W-1:0]  lane_pos;

  assign lane_pos = {1'b0, sign_pos[POS_W-2:0]};
  assign full_fmt = extend_from(raw, sign_pos, signed_mode);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DATA_W-1:0] wide;
    assign wide = extend_from(DATA_W'(raw[g*HALF_W +: HALF_W]), lane_pos, signed_mode);
    assign lane_fmt[g*HALF_W +: HALF_W] = wide[HALF_W-1:0];
  end

  assign fmt = width16 ? lane_fmt : full_fmt;
endmodule

// File: rtl/dec_accum.sv
module dec_accum #(
  parameter int DATA_W  = 32,
  parameter int DIV_W   = 16,
  parameter int MAX_LOG = 12,
  parameter int LOG_W   = 4,
  parameter int LANES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] sample,
  input  logic              avg_en,
  input  logic              width16,
  input  logic              signed_mode,
  input  logic [DIV_W-1:0]  words,
  input  logic [LOG_W-1:0]  shift,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int HALF_W = DATA_W / LANES;
  localparam int ACC_W  = DATA_W + MAX_LOG;
  localparam int LANE_W = HALF_W + MAX_LOG;

  logic [DIV_W-1:0]            cnt_q, cnt_d;
  logic [ACC_W-1:0]            acc_q, acc_d, acc_sum, full_mean;
  logic signed [ACC_W-1:0]     acc_s, acc_sh;
  logic [LANES-1:0][LANE_W-1:0] lane_q, lane_d, lane_sum, lane_mean;
  logic signed [LANE_W-1:0]    lane_s, lane_sh;
  logic [DATA_W-1:0]           avg_word, result;
  logic                        last;
  logic                        ov_q, ov_d;
  logic [DATA_W-1:0]           od_q, od_d;

  always_comb begin
    acc_sum = acc_q + {{(ACC_W-DATA_W){signed_mode & sample[DATA_W-1]}}, sample};
    acc_s   = $signed(acc_sum);
    acc_sh  = acc_s >>> shift;
    full_mean = signed_mode ? acc_sh : (acc_sum >> shift);
    avg_word = '0;
    lane_s = '0;
    lane_sh = '0;
    for (int l = 0; l < LANES; l++) begin
      lane_sum[l] = lane_q[l] +
        {{(LANE_W-HALF_W){signed_mode & sample[l*HALF_W+HALF_W-1]}}, sample[l*HALF_W +: HALF_W]};
      lane_s  = $signed(lane_sum[l]);
      lane_sh = lane_s >>> shift;
      lane_mean[l] = signed_mode ? lane_sh : (lane_sum[l] >> shift);
      avg_word[l*HALF_W +: HALF_W] = lane_mean[l][HALF_W-1:0];
    end
    if (!width16) avg_word = full_mean[DATA_W-1:0];
    result = avg_en ? avg_word : sample;
  end

  always_comb begin
    last   = in_valid && (cnt_q == words - DIV_W'(1));
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    lane_d = lane_q;
    ov_d   = last;
    od_d   = last ? result : od_q;
    if (in_valid) begin
      if (last) begin
        cnt_d  = '0;
        acc_d  = '0;
        lane_d = '0;
      end else begin
        cnt_d  = cnt_q + DIV_W'(1);
        acc_d  = acc_sum;
        lane_d = lane_sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      lane_q <= '0;
      ov_q   <= 1'b0;
      od_q   <= '0;
    end else begin
      if (in_valid) begin
        cnt_q  <= cnt_d;
        acc_q  <= acc_d;
        lane_q <= lane_d;
      end
      ov_q <= ov_d;
      if (last) od_q <= od_d;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;

  // R9: no output without a completing input word on the cycle before
  assert_idle_no_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R9: output data holds between results
  assert_hold_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_data == $past(out_data));

  // R4: position within a group stays below the group length
  assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < words);

  // R4: without averaging the result is the formatted completing word
  assert_passthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!avg_en && in_valid && cnt_q == words - DIV_W'(1)) |=> out_data == $past(sample));

  // R5: unit group length emits on every valid word
  assert_unit_rate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (words == DIV_W'(1) && in_valid) |=> out_valid);
endmodule

// File: rtl/dec_avg_fmt.sv
module dec_avg_fmt
  import dec_pkg::*;
#(
  parameter int DATA_W  = WORD_W,
  parameter int DIV_W   = 16,
  parameter int MAX_LOG = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [DIV_W-1:0]  div,
  input  logic              avg_en,
  input  logic              width16,
  input  logic              signed_mode,
  input  logic [POS_W-1:0]  sign_pos,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int LOG_W = $clog2(DIV_W);

  logic [DIV_W-1:0]  words;
  logic [LOG_W-1:0]  shift;
  logic [DATA_W-1:0] fmt;

  dec_rate #(.DIV_W(DIV_W), .MAX_LOG(MAX_LOG), .LOG_W(LOG_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .div(div), .avg_en(avg_en), .width16(width16),
    .words(words), .shift(shift));

  dec_format #(.DATA_W(DATA_W)) u_fmt (
    .raw(in_data), .width16(width16), .signed_mode(signed_mode),
    .sign_pos(sign_pos), .fmt(fmt));

  dec_accum #(.DATA_W(DATA_W), .DIV_W(DIV_W), .MAX_LOG(MAX_LOG), .LOG_W(LOG_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sample(fmt),
    .avg_en(avg_en), .width16(width16), .signed_mode(signed_mode),
    .words(words), .shift(shift), .out_valid(out_valid), .out_data(out_data));

  // R1: no output is flagged on the first cycle out of reset
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);
endmodule

// File: tb/dec_avg_fmt_test.sv
`timescale 1ns/1ps
module dec_avg_fmt_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_data;
  logic [15:0] div;
  logic        avg_en, width16, signed_mode;
  logic [4:0]  sign_pos;
  logic        out_valid;
  logic [31:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #4 clk = ~clk;

  dec_avg_fmt uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .div(div), .avg_en(avg_en), .width16(width16), .signed_mode(signed_mode),
    .sign_pos(sign_pos), .out_valid(out_valid), .out_data(out_data));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic longint fmt_val(input longint x, input int p, input bit sgn);
    longint m;
    m = x % (longint'(1) << (p + 1));
    if (sgn && m >= (longint'(1) << p)) m = m - (longint'(1) << (p + 1));
    return m;
  endfunction

  function automatic longint floor_div(input longint a, input longint b);
    longint q;
    q = a / b;
    if (a < 0 && q * b != a) q = q - 1;
    return q;
  endfunction

  function automatic logic [31:0] next_rng(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic run_cfg(input bit a, input bit w, input bit s, input int d, input int p,
                         input int nsamp);
    longint n0, p2, words, sum0, sum1, v0, v1, m0, m1;
    int cnt;
    bit exp_v;
    logic [31:0] exp_d;
    string tag;
    n0 = (d == 0) ? 1 : d;
    if (a) begin
      p2 = 1;
      while (p2 * 2 <= n0) p2 = p2 * 2;
      if (p2 > 4096) p2 = 4096;
      words = w ? ((p2 > 1) ? p2 / 2 : 1) : p2;
      tag = w ? "R8 R3" : "R7 R2";
    end else begin
      words = w ? ((n0 / 2 < 1) ? 1 : n0 / 2) : n0;
      tag = w ? "R6 R3" : "R4 R2";
    end
    if (d == 0) tag = {tag, " R5"};
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    div = 16'(d);
    avg_en = a;
    width16 = w;
    signed_mode = s;
    sign_pos = 5'(p);
    @(negedge clk);
    check("R1 valid in reset", {31'b0, out_valid}, 32'h0);
    check("R1 data in reset", out_data, 32'h0);
    rst_n = 1'b1;
    cnt = 0; sum0 = 0; sum1 = 0; exp_v = 0; exp_d = '0;
    for (int i = 0; i <= nsamp; i++) begin
      @(negedge clk);
      check("R9 out_valid timing", {31'b0, out_valid}, {31'b0, exp_v});
      check({tag, " R9 data"}, out_data, exp_d);
      if (i == nsamp) break;
      rng = next_rng(rng);
      in_valid = !((i % 7 == 3) || (i % 11 == 5));
      in_data = rng;
      exp_v = 0;
      if (in_valid) begin
        if (w) begin
          v0 = fmt_val(longint'(rng[15:0]), p % 16, s);
          v1 = fmt_val(longint'(rng[31:16]), p % 16, s);
        end else begin
          v0 = fmt_val(longint'(rng), p, s);
          v1 = 0;
        end
        sum0 = sum0 + v0;
        sum1 = sum1 + v1;
        cnt++;
        if (cnt == words) begin
          exp_v = 1;
          if (a) begin
            m0 = floor_div(sum0, words);
            m1 = floor_div(sum1, words);
          end else begin
            m0 = v0;
            m1 = v1;
          end
          if (w) exp_d = {m1[15:0], m0[15:0]};
          else   exp_d = m0[31:0];
          cnt = 0; sum0 = 0; sum1 = 0;
        end
      end
    end
    in_valid = 1'b0;
  endtask

  initial begin
    int divs[8] = '{0, 1, 2, 3, 4, 6, 7, 16};
    int poss[4] = '{3, 15, 19, 31};
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    div = '0;
    avg_en = 0; width16 = 0; signed_mode = 0; sign_pos = '0;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 2; a++)
      for (int w = 0; w < 2; w++)
        for (int s = 0; s < 2; s++)
          for (int di = 0; di < 8; di++)
            for (int pi = 0; pi < 4; pi++)
              run_cfg(a[0], w[0], s[0], divs[di], poss[pi], 48);
    // R7 cap: a divider above 4096 averages 4096 words
    run_cfg(1'b1, 1'b0, 1'b1, 65535, 31, 9000);
    // R8 cap: lanes average 2048 words
    run_cfg(1'b1, 1'b1, 1'b0, 40000, 15, 4800);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R9 actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule